// File: doc/BRIEF.md
# Split Descriptor Ring Controller

This block owns a table of buffer descriptors that a network MAC shares between its transmit and receive paths. Each table entry holds two 32-bit words: a length/flags word and a buffer pointer. A programmable split value divides the table. Entries below the split form the transmit ring, and entries from the split to the last entry form the receive ring. The block keeps one current index for each ring. It decides when the MAC may start a transmit and when it may accept a received frame. When the MAC reports completion, the block writes the result back into the descriptor, moves the ring index on, and raises interrupt-source bits.

Software reaches the table through a plain word-wide read/write port. The MAC sees a start pulse with the descriptor's length and pointer for transmit, and a ready level with the pointer for receive. It answers each with a one-cycle done strobe. Moving frame data, padding and CRC generation belong to other blocks.

Top module: `desc_ring_ctrl`

## Requirements
- R1: After synchronous reset, the transmit index is 0, the receive index and split value are 64 (half the table), the interrupt sources are 0, and every table word reads as 0.
- R2: The host port takes a byte address. Bits [9:3] select the entry and bit 2 selects the word: 0 is length/flags, 1 is the buffer pointer. A write lands at the clock edge. Read data is registered and appears one cycle after the address.
- R3: `tx_start` pulses for one cycle when all of these hold: transmit is enabled, it is not the first cycle of that enable, no transmit is in flight, the split is nonzero, the current descriptor's ready bit (bit 15) is 1, and its length field (bits 31:16) is above 4. `tx_len` and `tx_ptr` then hold that descriptor's length and pointer.
- R4: On `tx_done` during a transmit, the descriptor keeps its length and bits 14:9, and bits 15 and 8:0 are cleared. A `tx_done` with no transmit in flight has no effect.
- R5: After a transmit completes, the transmit index goes to 0 if the descriptor's wrap bit (bit 13) was set. Otherwise it increments, and returns to 0 when it reaches the split.
- R6: `rx_ready` is high when receive is enabled, it is not the first cycle of that enable, the split is below 128, and the current receive descriptor's empty bit (bit 15) is 1.
- R7: On `rx_done` while `rx_ready` is high, the descriptor's length becomes `rx_len`, bit 15 is cleared, bits 14:9 are kept, and bits 8:0 are replaced by `rx_status`. An `rx_done` while `rx_ready` is low changes nothing.
- R8: After a receive completes, the receive index returns to the split if the descriptor's wrap bit (bit 13) was set or the index is 127. Otherwise it increments.
- R9: A rising edge of `tx_en` sets the transmit index to 0. A rising edge of `rx_en` sets the receive index to the split value.
- R10: A completed descriptor with bit 14 set raises interrupt source bit 0 (transmit) or bit 2 (receive). A clear strobe clears only the bits written as 1. A set in the same cycle wins over a clear. `irq` is high when any source bit is high together with its mask bit.
- R11: When a host write and a MAC write-back target the same length/flags word in the same cycle, the write-back is kept.
- R12: A transmit completion and a receive completion in the same cycle both take full effect: both write-backs, both index moves and both interrupt bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host table write strobe |
| host_addr | input | 10 | Host byte address into the table |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| split_we | input | 1 | Split value write strobe |
| split_wdata | input | 8 | New split value |
| tx_en | input | 1 | Transmit enable level |
| rx_en | input | 1 | Receive enable level |
| irq_clr_we | input | 1 | Interrupt source clear strobe |
| irq_clr | input | 3 | Source bits to clear |
| irq_mask | input | 3 | Interrupt mask |
| irq_src | output | 3 | Interrupt source bits |
| irq | output | 1 | Interrupt request |
| tx_start | output | 1 | One-cycle transmit start |
| tx_idx | output | 7 | Current transmit index |
| tx_len | output | 16 | Length of the started descriptor |
| tx_ptr | output | 32 | Buffer pointer of the started descriptor |
| tx_done | input | 1 | Transmit completion strobe |
| rx_ready | output | 1 | Receive descriptor available |
| rx_idx | output | 7 | Current receive index |
| rx_ptr | output | 32 | Buffer pointer of the current receive descriptor |
| rx_done | input | 1 | Receive completion strobe |
| rx_len | input | 16 | Received length to write back |
| rx_status | input | 9 | Receive status bits to write back |

## Verification
Two pairs of events can fall in the same cycle. The first is a transmit write-back together with a receive write-back. The bench provokes it by holding a transmit in flight and a receive descriptor ready, then strobing both done inputs on one edge while also clearing the interrupt bits they set. It judges the result from both descriptors read back, both indices, and the source bits, which must still be set. The second is a host write to the descriptor being written back. That is driven on the same edge as `tx_done`, and the read-back must show the retired MAC value, not the host data.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;

    localparam int WORD_W = 32;
    localparam int LEN_W  = 16;
    localparam int STAT_W = 9;
    localparam int ISRC_W = 3;
    localparam int ISRC_TX = 0;
    localparam int ISRC_RX = 2;

    // View of a length/flags word
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic              own;    // ready (tx) / empty (rx)
        logic              intr;
        logic              wrap;
        logic [3:0]        mid;
        logic [STAT_W-1:0] stat;
    } bd_flags_t;

    // Transmit write-back: drop ownership and all status
    function automatic bd_flags_t tx_retire(input bd_flags_t f);
        bd_flags_t r;
        r      = f;
        r.own  = 1'b0;
        r.stat = '0;
        return r;
    endfunction

    // Receive write-back: new length and status, drop ownership
    function automatic bd_flags_t rx_retire(input bd_flags_t f,
                                            input logic [LEN_W-1:0] len,
                                            input logic [STAT_W-1:0] st);
        bd_flags_t r;
        r      = f;
        r.len  = len;
        r.own  = 1'b0;
        r.stat = st;
        return r;
    endfunction

endpackage

// File: rtl/dr_table.sv
module dr_table
    import desc_ring_pkg::*;
#(
    parameter int N_DESC = 128,
    parameter int IDX_W  = $clog2(N_DESC),
    parameter int ADDR_W = IDX_W + 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              tx_wb_en,
    input  logic [IDX_W-1:0]  tx_wb_idx,
    input  logic [WORD_W-1:0] tx_wb_data,
    input  logic              rx_wb_en,
    input  logic [IDX_W-1:0]  rx_wb_idx,
    input  logic [WORD_W-1:0] rx_wb_data,
    input  logic [IDX_W-1:0]  tx_rd_idx,
    output logic [WORD_W-1:0] tx_rd_flags,
    output logic [WORD_W-1:0] tx_rd_ptr,
    input  logic [IDX_W-1:0]  rx_rd_idx,
    output logic [WORD_W-1:0] rx_rd_flags,
    output logic [WORD_W-1:0] rx_rd_ptr
);

    logic [WORD_W-1:0] flags_q [N_DESC];
    logic [WORD_W-1:0] ptr_q   [N_DESC];

    logic [IDX_W-1:0] h_entry;
    logic             h_sel_ptr;
    logic             unused_lsb;

    assign h_entry    = host_addr[ADDR_W-1:3];
    assign h_sel_ptr  = host_addr[2];
    assign unused_lsb = ^host_addr[1:0];

    always_ff @(posedge clk) begin
        for (int e = 0; e < N_DESC; e++) begin
            if (rst) begin
                flags_q[e] <= '0;
                ptr_q[e]   <= '0;
            end else begin
                // write-back ports outrank the host
                if (rx_wb_en && rx_wb_idx == IDX_W'(e))
                    flags_q[e] <= rx_wb_data;
                else if (tx_wb_en && tx_wb_idx == IDX_W'(e))
                    flags_q[e] <= tx_wb_data;
                else if (host_we && !h_sel_ptr && h_entry == IDX_W'(e))
                    flags_q[e] <= host_wdata;
                if (host_we && h_sel_ptr && h_entry == IDX_W'(e))
                    ptr_q[e] <= host_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) host_rdata <= '0;
        else     host_rdata <= h_sel_ptr ? ptr_q[h_entry] : flags_q[h_entry];
    end

    assign tx_rd_flags = flags_q[tx_rd_idx];
    assign tx_rd_ptr   = ptr_q[tx_rd_idx];
    assign rx_rd_flags = flags_q[rx_rd_idx];
    assign rx_rd_ptr   = ptr_q[rx_rd_idx];

    a_r11_tx_wb_kept: assert property (@(posedge clk) disable iff (rst)
        (tx_wb_en && !(rx_wb_en && rx_wb_idx == tx_wb_idx))
        |=> flags_q[$past(tx_wb_idx)] == $past(tx_wb_data));

    a_r11_rx_wb_kept: assert property (@(posedge clk) disable iff (rst)
        rx_wb_en |=> flags_q[$past(rx_wb_idx)] == $past(rx_wb_data));

endmodule

// File: rtl/dr_tx_ring.sv
module dr_tx_ring
    import desc_ring_pkg::*;
#(
    parameter int N_DESC = 128,
    parameter int IDX_W  = $clog2(N_DESC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_en,
    input  logic [IDX_W:0]    split,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic [WORD_W-1:0] cur_ptr,
    input  logic              tx_done,
    output logic [IDX_W-1:0]  idx,
    output logic              tx_start,
    output logic [LEN_W-1:0]  tx_len,
    output logic [WORD_W-1:0] tx_ptr,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_data,
    output logic              irq_set
);

    localparam logic [IDX_W:0]   ONE     = (IDX_W+1)'(1);
    localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(4);

    bd_flags_t        cur;
    logic             en_q, busy_q, start_q;
    logic [IDX_W-1:0] idx_q;
    logic             rise, can_go, retire;
    logic [IDX_W:0]   inc;
    logic [IDX_W-1:0] idx_next;

    assign cur    = bd_flags_t'(cur_flags);
    assign rise   = tx_en && !en_q;
    assign can_go = tx_en && !rise && !busy_q && (split != '0)
                    && cur.own && (cur.len > MIN_LEN);
    assign retire = busy_q && tx_done;
    assign inc    = {1'b0, idx_q} + ONE;

    always_comb begin
        if (cur.wrap || inc >= split) idx_next = '0;
        else                          idx_next = inc[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
            idx_q   <= '0;
            tx_len  <= '0;
            tx_ptr  <= '0;
        end else begin
            en_q    <= tx_en;
            start_q <= can_go;
            if (can_go) begin
                busy_q <= 1'b1;
                tx_len <= cur.len;
                tx_ptr <= cur_ptr;
            end else if (retire) begin
                busy_q <= 1'b0;
            end
            if (rise)        idx_q <= '0;
            else if (retire) idx_q <= idx_next;
        end
    end

    assign idx      = idx_q;
    assign tx_start = start_q;
    assign wb_en    = retire;
    assign wb_data  = tx_retire(cur);
    assign irq_set  = retire && cur.intr;

    a_r3_start_single: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    a_r3_hold_in_flight: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !tx_done && !rise) |=> $stable(idx_q));

    a_r5_step_or_zero: assert property (@(posedge clk) disable iff (rst)
        (retire && !rise) |=> (idx_q == '0 || idx_q == $past(idx_q) + 1'b1));

    a_r9_tx_restart: assert property (@(posedge clk) disable iff (rst)
        rise |=> idx_q == '0);

endmodule

// File: rtl/dr_rx_ring.sv
module dr_rx_ring
    import desc_ring_pkg::*;
#(
    parameter int N_DESC    = 128,
    parameter int IDX_W     = $clog2(N_DESC),
    parameter int SPLIT_RST = N_DESC / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_en,
    input  logic [IDX_W:0]    split,
    input  logic [WORD_W-1:0] cur_flags,
    input  logic              rx_done,
    input  logic [LEN_W-1:0]  rx_len,
    input  logic [STAT_W-1:0] rx_status,
    output logic [IDX_W-1:0]  idx,
    output logic              rx_ready,
    output logic              wb_en,
    output logic [WORD_W-1:0] wb_data,
    output logic              irq_set
);

    localparam logic [IDX_W:0]   LIMIT    = (IDX_W+1)'(N_DESC);
    localparam logic [IDX_W-1:0] LAST     = IDX_W'(N_DESC - 1);
    localparam logic [IDX_W-1:0] IDX_INIT = IDX_W'(SPLIT_RST);

    bd_flags_t        cur;
    logic             en_q;
    logic [IDX_W-1:0] idx_q;
    logic             rise, ready, accept;
    logic [IDX_W-1:0] idx_next;
    logic             unused_bits;

    assign cur         = bd_flags_t'(cur_flags);
    assign unused_bits = ^{cur.len, cur.mid, cur.stat};
    assign rise        = rx_en && !en_q;
    assign ready       = rx_en && !rise && (split < LIMIT) && cur.own;
    assign accept      = ready && rx_done;

    always_comb begin
        if (cur.wrap || idx_q == LAST) idx_next = split[IDX_W-1:0];
        else                           idx_next = idx_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            idx_q <= IDX_INIT;
        end else begin
            en_q <= rx_en;
            if (rise)        idx_q <= split[IDX_W-1:0];
            else if (accept) idx_q <= idx_next;
        end
    end

    assign idx      = idx_q;
    assign rx_ready = ready;
    assign wb_en    = accept;
    assign wb_data  = rx_retire(cur, rx_len, rx_status);
    assign irq_set  = accept && cur.intr;

    a_r7_done_ignored: assert property (@(posedge clk) disable iff (rst)
        (rx_done && !ready && !rise) |=> $stable(idx_q));

    a_r9_rx_restart: assert property (@(posedge clk) disable iff (rst)
        rise |=> idx_q == $past(split[IDX_W-1:0]));

endmodule

// File: rtl/dr_irq.sv
module dr_irq
    import desc_ring_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tx_set,
    input  logic              rx_set,
    input  logic              clr_we,
    input  logic [ISRC_W-1:0] clr_bits,
    input  logic [ISRC_W-1:0] mask,
    output logic [ISRC_W-1:0] src,
    output logic              irq
);

    logic [ISRC_W-1:0] src_q, set_v, clr_v;

    always_comb begin
        set_v          = '0;
        set_v[ISRC_TX] = tx_set;
        set_v[ISRC_RX] = rx_set;
        clr_v          = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) src_q <= '0;
        else     src_q <= (src_q & ~clr_v) | set_v;
    end

    assign src = src_q;
    assign irq = |(src_q & mask);

    a_r10_tx_sets: assert property (@(posedge clk) disable iff (rst)
        tx_set |=> src_q[ISRC_TX]);

    a_r10_rx_sets: assert property (@(posedge clk) disable iff (rst)
        rx_set |=> src_q[ISRC_RX]);

    a_r10_w1c_tx: assert property (@(posedge clk) disable iff (rst)
        (clr_we && clr_bits[ISRC_TX] && !tx_set) |=> !src_q[ISRC_TX]);

endmodule

// File: rtl/desc_ring_ctrl.sv
module desc_ring_ctrl
    import desc_ring_pkg::*;
#(
    parameter int N_DESC    = 128,
    parameter int IDX_W     = $clog2(N_DESC),
    parameter int ADDR_W    = IDX_W + 3,
    parameter int SPLIT_RST = N_DESC / 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic              split_we,
    input  logic [IDX_W:0]    split_wdata,
    input  logic              tx_en,
    input  logic              rx_en,
    input  logic              irq_clr_we,
    input  logic [2:0]        irq_clr,
    input  logic [2:0]        irq_mask,
    output logic [2:0]        irq_src,
    output logic              irq,
    output logic              tx_start,
    output logic [IDX_W-1:0]  tx_idx,
    output logic [15:0]       tx_len,
    output logic [31:0]       tx_ptr,
    input  logic              tx_done,
    output logic              rx_ready,
    output logic [IDX_W-1:0]  rx_idx,
    output logic [31:0]       rx_ptr,
    input  logic              rx_done,
    input  logic [15:0]       rx_len,
    input  logic [8:0]        rx_status
);

    localparam logic [IDX_W:0] SPLIT_INIT = (IDX_W+1)'(SPLIT_RST);

    logic [IDX_W:0]    split_q;
    logic [WORD_W-1:0] tx_cur_flags, tx_cur_ptr, rx_cur_flags;
    logic              tx_wb_en, rx_wb_en, tx_irq_set, rx_irq_set;
    logic [WORD_W-1:0] tx_wb_data, rx_wb_data;

    always_ff @(posedge clk) begin
        if (rst)           split_q <= SPLIT_INIT;
        else if (split_we) split_q <= split_wdata;
    end

    dr_table #(.N_DESC(N_DESC), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_table (
        .clk         (clk),
        .rst         (rst),
        .host_we     (host_we),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .tx_wb_en    (tx_wb_en),
        .tx_wb_idx   (tx_idx),
        .tx_wb_data  (tx_wb_data),
        .rx_wb_en    (rx_wb_en),
        .rx_wb_idx   (rx_idx),
        .rx_wb_data  (rx_wb_data),
        .tx_rd_idx   (tx_idx),
        .tx_rd_flags (tx_cur_flags),
        .tx_rd_ptr   (tx_cur_ptr),
        .rx_rd_idx   (rx_idx),
        .rx_rd_flags (rx_cur_flags),
        .rx_rd_ptr   (rx_ptr)
    );

    dr_tx_ring #(.N_DESC(N_DESC), .IDX_W(IDX_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .tx_en     (tx_en),
        .split     (split_q),
        .cur_flags (tx_cur_flags),
        .cur_ptr   (tx_cur_ptr),
        .tx_done   (tx_done),
        .idx       (tx_idx),
        .tx_start  (tx_start),
        .tx_len    (tx_len),
        .tx_ptr    (tx_ptr),
        .wb_en     (tx_wb_en),
        .wb_data   (tx_wb_data),
        .irq_set   (tx_irq_set)
    );

    dr_rx_ring #(.N_DESC(N_DESC), .IDX_W(IDX_W), .SPLIT_RST(SPLIT_RST)) u_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_en     (rx_en),
        .split     (split_q),
        .cur_flags (rx_cur_flags),
        .rx_done   (rx_done),
        .rx_len    (rx_len),
        .rx_status (rx_status),
        .idx       (rx_idx),
        .rx_ready  (rx_ready),
        .wb_en     (rx_wb_en),
        .wb_data   (rx_wb_data),
        .irq_set   (rx_irq_set)
    );

    dr_irq u_irq (
        .clk      (clk),
        .rst      (rst),
        .tx_set   (tx_irq_set),
        .rx_set   (rx_irq_set),
        .clr_we   (irq_clr_we),
        .clr_bits (irq_clr),
        .mask     (irq_mask),
        .src      (irq_src),
        .irq      (irq)
    );

    a_r12_both_retire: assert property (@(posedge clk) disable iff (rst)
        (tx_irq_set && rx_irq_set) |=> (irq_src[0] && irq_src[2]));

endmodule

// File: tb/desc_ring_ctrl_tb.sv
module desc_ring_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_we = 1'b0;
    logic [9:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        split_we = 1'b0;
    logic [7:0]  split_wdata = '0;
    logic        tx_en = 1'b0, rx_en = 1'b0;
    logic        irq_clr_we = 1'b0;
    logic [2:0]  irq_clr = '0, irq_mask = 3'b111;
    logic [2:0]  irq_src;
    logic        irq, tx_start, tx_done = 1'b0, rx_ready, rx_done = 1'b0;
    logic [6:0]  tx_idx, rx_idx;
    logic [15:0] tx_len, rx_len = '0;
    logic [31:0] tx_ptr, rx_ptr;
    logic [8:0]  rx_status = '0;

    int checks = 0;
    int errors = 0;
    logic [31:0] rd_val;

    always #5 clk = ~clk;

    desc_ring_ctrl u_dut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .split_we(split_we), .split_wdata(split_wdata),
        .tx_en(tx_en), .rx_en(rx_en), .irq_clr_we(irq_clr_we),
        .irq_clr(irq_clr), .irq_mask(irq_mask), .irq_src(irq_src), .irq(irq),
        .tx_start(tx_start), .tx_idx(tx_idx), .tx_len(tx_len), .tx_ptr(tx_ptr),
        .tx_done(tx_done), .rx_ready(rx_ready), .rx_idx(rx_idx), .rx_ptr(rx_ptr),
        .rx_done(rx_done), .rx_len(rx_len), .rx_status(rx_status)
    );

    typedef struct packed {
        logic [15:0] len;
        logic [15:0] flags;
        logic        go;
        logic [31:0] word_after;
        logic [6:0]  idx_after;
        logic        irq_after;
    } tx_vec_t;

    localparam tx_vec_t VECS [5] = '{
        '{len:16'd60,  flags:16'h8000, go:1'b1, word_after:32'h003C0000, idx_after:7'd1, irq_after:1'b0},
        '{len:16'd4,   flags:16'h8000, go:1'b0, word_after:32'h00048000, idx_after:7'd0, irq_after:1'b0},
        '{len:16'd5,   flags:16'hC9FF, go:1'b1, word_after:32'h00054800, idx_after:7'd1, irq_after:1'b1},
        '{len:16'd100, flags:16'h7000, go:1'b0, word_after:32'h00647000, idx_after:7'd0, irq_after:1'b0},
        '{len:16'd100, flags:16'hA000, go:1'b1, word_after:32'h00642000, idx_after:7'd0, irq_after:1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        tick();
        host_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a);
        host_addr = a;
        tick();
        rd_val = host_rdata;
    endtask

    task automatic set_split(input logic [7:0] v);
        split_we = 1'b1; split_wdata = v;
        tick();
        split_we = 1'b0;
    endtask

    task automatic clear_src(input logic [2:0] b);
        irq_clr_we = 1'b1; irq_clr = b;
        tick();
        irq_clr_we = 1'b0; irq_clr = '0;
    endtask

    task automatic pulse_tx_done();
        tx_done = 1'b1;
        tick();
        tx_done = 1'b0;
    endtask

    task automatic pulse_rx_done(input logic [15:0] l, input logic [8:0] s);
        rx_done = 1'b1; rx_len = l; rx_status = s;
        tick();
        rx_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 tx_idx", 32'(tx_idx), 32'd0);
        chk("R1 rx_idx", 32'(rx_idx), 32'd64);
        chk("R1 irq_src", 32'(irq_src), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 tx_start", 32'(tx_start), 32'd0);
        chk("R1 rx_ready", 32'(rx_ready), 32'd0);
        rd(10'h3F8);
        chk("R1 table word", rd_val, 32'd0);

        // vector walk over transmit gating and retirement
        tx_en = 1'b1;
        tick();
        foreach (VECS[i]) begin
            chk("R9 tx idx after enable edge", 32'(tx_idx), 32'd0);
            wr(10'h000, {VECS[i].len, VECS[i].flags});
            tick();
            chk("R3 tx_start gating", 32'(tx_start), 32'(VECS[i].go));
            if (VECS[i].go) begin
                chk("R3 tx_len", 32'(tx_len), 32'(VECS[i].len));
                pulse_tx_done();
            end else begin
                tick();
                chk("R3 no late start", 32'(tx_start), 32'd0);
            end
            chk("R5 tx idx after", 32'(tx_idx), 32'(VECS[i].idx_after));
            chk("R10 tx source", 32'(irq_src[0]), 32'(VECS[i].irq_after));
            chk("R10 irq level", 32'(irq), 32'(VECS[i].irq_after));
            rd(10'h000);
            chk("R4 tx write-back", rd_val, VECS[i].word_after);
            clear_src(3'b111);
            tx_en = 1'b0;
            tick();
            tx_en = 1'b1;
            tick();
        end

        // R5 ring limit at split
        set_split(8'd2);
        wr(10'h008, 32'h000A8000);
        wr(10'h000, 32'h000A8000);
        tick();
        chk("R3 start on entry 0", 32'(tx_start), 32'd1);
        pulse_tx_done();
        chk("R5 step to 1", 32'(tx_idx), 32'd1);
        tick();
        chk("R3 start on entry 1", 32'(tx_start), 32'd1);
        pulse_tx_done();
        chk("R5 wrap at split", 32'(tx_idx), 32'd0);
        tick();
        chk("R4 retired entry not restarted", 32'(tx_start), 32'd0);
        pulse_tx_done();
        chk("R4 stray tx_done ignored", 32'(tx_idx), 32'd0);

        // R3 split of zero blocks transmit
        set_split(8'd0);
        wr(10'h000, 32'h000A8000);
        tick();
        chk("R3 zero split", 32'(tx_start), 32'd0);
        tick();
        chk("R3 zero split later", 32'(tx_start), 32'd0);
        set_split(8'd64);
        tick();
        chk("R3 start after split restored", 32'(tx_start), 32'd1);

        // R11 host write collides with write-back
        tx_done = 1'b1;
        host_we = 1'b1; host_addr = 10'h000; host_wdata = 32'h00FF8000;
        tick();
        tx_done = 1'b0; host_we = 1'b0;
        rd(10'h000);
        chk("R11 write-back kept", rd_val, 32'h000A0000);
        chk("R11 idx moved", 32'(tx_idx), 32'd1);

        // R12 simultaneous completions, with a clear on the same edge
        wr(10'h00C, 32'h12345678);
        wr(10'h008, 32'h0020C000);
        tick();
        chk("R3 start entry 1", 32'(tx_start), 32'd1);
        chk("R2 pointer word", tx_ptr, 32'h12345678);
        wr(10'h204, 32'hCAFE0000);
        wr(10'h200, 32'h0000C000);
        rx_en = 1'b1;
        tick();
        chk("R6 rx_ready", 32'(rx_ready), 32'd1);
        chk("R9 rx idx at split", 32'(rx_idx), 32'd64);
        chk("R2 rx pointer", rx_ptr, 32'hCAFE0000);
        tx_done = 1'b1; rx_done = 1'b1; rx_len = 16'h0040; rx_status = 9'h004;
        irq_clr_we = 1'b1; irq_clr = 3'b101;
        tick();
        tx_done = 1'b0; rx_done = 1'b0; irq_clr_we = 1'b0; irq_clr = '0;
        chk("R12 tx idx", 32'(tx_idx), 32'd2);
        chk("R12 rx idx", 32'(rx_idx), 32'd65);
        chk("R12 R10 set beats clear", 32'(irq_src), 32'b101);
        rd(10'h200);
        chk("R12 R7 rx write-back", rd_val, 32'h00404004);
        rd(10'h008);
        chk("R12 R4 tx write-back", rd_val, 32'h00204000);

        // R10 masking and selective clear
        irq_mask = 3'b000;
        tick();
        chk("R10 masked", 32'(irq), 32'd0);
        irq_mask = 3'b100;
        tick();
        chk("R10 rx unmasked", 32'(irq), 32'd1);
        clear_src(3'b001);
        chk("R10 clear one bit", 32'(irq_src), 32'b100);
        irq_mask = 3'b001;
        tick();
        chk("R10 mask off remaining", 32'(irq), 32'd0);
        irq_mask = 3'b111;
        clear_src(3'b111);

        // R7 R8 wrap flag on receive
        wr(10'h208, 32'h0000A1FF);
        chk("R6 ready on entry 65", 32'(rx_ready), 32'd1);
        pulse_rx_done(16'h003C, 9'h080);
        chk("R8 wrap to split", 32'(rx_idx), 32'd64);
        rd(10'h208);
        chk("R7 status replaced", rd_val, 32'h003C2080);
        chk("R10 no source without flag", 32'(irq_src), 32'd0);

        // R8 last entry returns to split
        set_split(8'h7E);
        rx_en = 1'b0;
        tick();
        rx_en = 1'b1;
        tick();
        chk("R9 rx idx to new split", 32'(rx_idx), 32'h7E);
        wr(10'h3F0, 32'h00008000);
        wr(10'h3F8, 32'h00008000);
        chk("R6 ready at 0x7E", 32'(rx_ready), 32'd1);
        pulse_rx_done(16'h0010, 9'h000);
        chk("R8 step to last", 32'(rx_idx), 32'h7F);
        pulse_rx_done(16'h0011, 9'h000);
        chk("R8 last returns to split", 32'(rx_idx), 32'h7E);
        chk("R6 not ready on consumed", 32'(rx_ready), 32'd0);
        pulse_rx_done(16'h0055, 9'h1FF);
        chk("R7 ignored done idx", 32'(rx_idx), 32'h7E);
        rd(10'h3F0);
        chk("R7 ignored done word", rd_val, 32'h00100000);
        chk("R7 ignored done source", 32'(irq_src), 32'd0);

        // R6 split of 128 blocks receive
        wr(10'h3F0, 32'h00008000);
        chk("R6 ready again", 32'(rx_ready), 32'd1);
        set_split(8'h80);
        chk("R6 split 128 blocks", 32'(rx_ready), 32'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule